// File: doc/BRIEF.md
# Lockable Cartridge Bank Register

This block is the control register of a plug-in cartridge, as the host computer sees it. The host writes it through the first of the cartridge's two I/O select regions. The register holds a one-bit ROM bank number and a memory-configuration bit. The configuration bit drives both of the cartridge's memory-map control lines, `cfgLineA` and `cfgLineB`. The register also holds a lock bit. Once the lock bit is set, the register takes no further writes until the next reset.

The block also builds the address for the cartridge ROM. A host read with either ROM window select active uses the bank bit as the top address bit and the low bits of the host offset below it. The ROM storage sits outside this block. The block flags a valid address only while a ROM window is selected.

Top module: `cartBankReg`

## Requirements
- R1: After reset, `bankSel`, `cfgLineA`, `cfgLineB` and `locked` are all 0.
- R2: While unlocked, a clock edge with `wrEn`=1 and `ioSel1`=1 loads data bit 0 into `bankSel` on the following cycle.
- R3: On such a write, data bit 1 drives both `cfgLineA` and `cfgLineB`, which always carry equal values.
- R4: On such a write, data bit 7 loads `locked`. Once `locked` is 1, every later write leaves `bankSel`, `cfgLineA`, `cfgLineB` and `locked` unchanged until reset.
- R5: Data bits 2 to 6 have no effect on any output.
- R6: A write with `ioSel1`=0, or with `wrEn`=0, changes nothing.
- R7: `romAddr` equals {`bankSel`, `hostOffset`[13:0]}, combinationally: bit 14 is the bank and bits 13:0 are the offset.
- R8: `romValid` is 1 exactly when `romLoSel` or `romHiSel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| ioSel1 | input | 1 | First I/O region select, active high |
| wrData | input | 8 | Host write data |
| romLoSel | input | 1 | Low ROM window select, active high |
| romHiSel | input | 1 | High ROM window select, active high |
| hostOffset | input | 16 | Host address offset |
| bankSel | output | 1 | Current ROM bank |
| cfgLineA | output | 1 | Memory-configuration line A |
| cfgLineB | output | 1 | Memory-configuration line B |
| locked | output | 1 | Lock bit; high once writes are barred |
| romAddr | output | 15 | ROM address |
| romValid | output | 1 | High while a ROM window is selected |

## Verification
The assertions check on every cycle that the outputs hold across a locked or unselected write, that the lock stays set until reset, and that the two configuration lines match. They also check that the ROM address and the valid flag follow their inputs. Only the bench scenarios show that each data bit lands in the right field, that the ignored bits have no effect, and that reset releases the lock. The bench sweeps every write data value and many offsets to cover these.

// File: rtl/cartBankPkg.sv
package cartBankPkg;
  localparam int DataW   = 8;
  localparam int OffW    = 16;
  localparam int WinBits = 14;
  localparam int AddrW   = WinBits + 1;
  localparam int BankBit = 0;
  localparam int CfgBit  = 1;
  localparam int LockBit = 7;

  typedef struct packed {
    logic load;
    logic clear;
  } regCtl_t;
endpackage

// File: rtl/cartBankCtl.sv
module cartBankCtl
  import cartBankPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrEn,
  input  logic    ioSel1,
  input  logic    locked,
  output regCtl_t ctl
);
  always_comb begin
    ctl.clear = !rstN;
    ctl.load  = rstN && wrEn && ioSel1 && !locked;
  end

  // R4: no load may be issued while the lock is set
  a_r4_no_load_locked: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !ctl.load);
  // R6: a load needs both the strobe and the select
  a_r6_load_needs_sel: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> (wrEn && ioSel1));
endmodule

// File: rtl/cartBankData.sv
module cartBankData
  import cartBankPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regCtl_t          ctl,
  input  logic [DataW-1:0] wrData,
  input  logic [OffW-1:0]  hostOffset,
  input  logic             romLoSel,
  input  logic             romHiSel,
  output logic             bankQ,
  output logic             cfgQ,
  output logic             lockQ,
  output logic [AddrW-1:0] romAddr,
  output logic             romValid
);
  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      bankQ <= 1'b0;
      cfgQ  <= 1'b0;
      lockQ <= 1'b0;
    end else if (ctl.load) begin
      bankQ <= wrData[BankBit];
      cfgQ  <= wrData[CfgBit];
      lockQ <= wrData[LockBit];
    end
  end

  always_comb begin
    romAddr  = {bankQ, hostOffset[WinBits-1:0]};
    romValid = romLoSel | romHiSel;
  end

  // R4: lock stays set until reset
  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && !ctl.clear) |=> lockQ);
  // R4/R6: without load, state holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.clear) |=> ($stable(bankQ) && $stable(cfgQ) && $stable(lockQ)));
  // R7: top address bit follows bank
  a_r7_addr_bank: assert property (@(posedge clk) disable iff (!rstN)
    romAddr[AddrW-1] == bankQ);
  // R8: valid follows window selects
  a_r8_valid: assert property (@(posedge clk) disable iff (!rstN)
    romValid == (romLoSel || romHiSel));
endmodule

// File: rtl/cartBankReg.sv
module cartBankReg
  import cartBankPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             ioSel1,
  input  logic [7:0]       wrData,
  input  logic             romLoSel,
  input  logic             romHiSel,
  input  logic [15:0]      hostOffset,
  output logic             bankSel,
  output logic             cfgLineA,
  output logic             cfgLineB,
  output logic             locked,
  output logic [14:0]      romAddr,
  output logic             romValid
);
  regCtl_t ctl;
  logic cfgQ;

  cartBankCtl uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .ioSel1(ioSel1),
    .locked(locked), .ctl(ctl)
  );

  cartBankData uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .hostOffset(hostOffset), .romLoSel(romLoSel), .romHiSel(romHiSel),
    .bankQ(bankSel), .cfgQ(cfgQ), .lockQ(locked),
    .romAddr(romAddr), .romValid(romValid)
  );

  assign cfgLineA = cfgQ;
  assign cfgLineB = cfgQ;

  // R3: both configuration lines agree
  a_r3_lines_equal: assert property (@(posedge clk) disable iff (!rstN)
    cfgLineA == cfgLineB);
endmodule

// File: tb/sim_cartBankReg.sv
module sim_cartBankReg;
  logic clk = 0, rstN = 0, wrEn = 0, ioSel1 = 0, romLoSel = 0, romHiSel = 0;
  logic [7:0] wrData = 0;
  logic [15:0] hostOffset = 0;
  logic bankSel, cfgLineA, cfgLineB, locked, romValid;
  logic [14:0] romAddr;
  int checks = 0, errors = 0;
  logic done = 0;

  always #2 clk = ~clk;

  cartBankReg u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 0; @(posedge clk); #1; rstN = 1;
  endtask

  task automatic wr(input logic [7:0] d, input logic sel, input logic en);
    wrData = d; ioSel1 = sel; wrEn = en;
    @(posedge clk); #1;
    wrEn = 0; ioSel1 = 0;
  endtask

  task automatic checkState(input string req, input logic b, input logic c, input logic l);
    chk(req, bankSel, b);
    chk(req, cfgLineA, c);
    chk(req, cfgLineB, c);
    chk(req, locked, l);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    doReset();
    checkState("R1", 0, 0, 0);
    // R2 R3 R4 R5: sweep all data values, reset between
    for (int d = 0; d < 256; d++) begin
      wr(d[7:0], 1, 1);
      checkState("R2 R3 R4 R5", d[0], d[1], d[7]);
      doReset();
      checkState("R1", 0, 0, 0);
    end
    // R6: unselected or unstrobed writes ignored
    wr(8'h03, 0, 1); checkState("R6", 0, 0, 0);
    wr(8'h03, 1, 0); checkState("R6", 0, 0, 0);
    // R4: lock then attempt writes
    wr(8'h83, 1, 1); checkState("R4", 1, 1, 1);
    for (int d = 0; d < 256; d++) begin
      wr(d[7:0], 1, 1);
      checkState("R4", 1, 1, 1);
    end
    doReset();
    checkState("R1", 0, 0, 0);
    wr(8'h01, 1, 1); checkState("R4", 1, 0, 0);
    // R7 R8: address and valid
    for (int b = 0; b < 2; b++) begin
      doReset();
      wr({7'd0, b[0]}, 1, 1);
      for (int o = 0; o < 65536; o += 257) begin
        for (int s = 0; s < 4; s++) begin
          hostOffset = o[15:0]; romLoSel = s[0]; romHiSel = s[1];
          #1;
          chk("R7", romAddr, b * 16384 + (o % 16384));
          chk("R8", romValid, s != 0);
        end
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule